// File: doc/BRIEF.md
# Three-Pair PWM Generator with Deadband and Fault Trip

This block drives three complementary PWM output pairs from one 16-bit time base. The time base either counts up and wraps, giving edge-aligned waveforms, or counts up and then down, giving centre-aligned waveforms. Each pair compares the counter against its own compare value. The result goes through a per-pair deadband stage, so that the high-side and low-side outputs of a pair are never active together.

Software writes the period and compare values into shadow registers through a simple write port. The block copies them into the working registers each time the counter sits at zero, so a new duty cycle or carrier frequency never cuts a period short.

An active-low fault input is synchronised and then qualified. It must stay low for a programmable number of consecutive clocks before it counts. Once qualified, it latches a trip that pulls the output enable low for every pair whose trip-enable bit is set. The trip also raises an interrupt line when the interrupt is enabled. The trip stays latched until a clear strobe arrives while the qualified fault is inactive.

Top module: `pwm_tripgen`

## Requirements
- R1: With control bit 0 at 0 (edge-aligned), the counter runs 0..P and then wraps, so one period lasts P+1 clocks. The raw pair signal is active while the counter is below that pair's compare value C.
- R2: With control bit 0 at 1 (centre-aligned), the counter runs 0..P..1 and back to 0, so one period lasts 2P clocks. The raw signal is active for 2C-1 clocks per period when 1 <= C <= P.
- R3: Each edge of a pair's raw signal makes the output that turns on do so D clocks after the output that turns off, where D is that pair's deadband. A pair's high and low outputs are never 1 in the same cycle. Per period, the high output is on for (raw-high length - D) clocks and the low output for (raw-low length - D) clocks, or for the whole period when the raw signal never changes.
- R4: Period (address 0) and compare values (address 3+i for pair i) are written into shadow registers. They take effect only when the counter is at zero. A compare write in the middle of a period leaves the rest of that period unchanged.
- R5: The fault input passes a two-flop synchroniser. fault_level rises only after the synchronised input has been low for at least Q consecutive clocks, where Q is the value at address 2 (reset value 4). With Q=4 and the input taken low just before edge 1, fault_level reads 1 after edge 6 and 0 after edge 5. A low pulse of 3 clocks is ignored.
- R6: A qualified fault latches a trip. Two clocks after fault_level rises, pwm_oe[i] goes to 0 for every pair i whose trip-enable bit (control bit 1+i, reset value 1) is set. Pairs with the bit clear keep pwm_oe[i] at 1.
- R7: The trip stays latched after the fault input returns high. A clear_fault strobe releases it only while fault_level is 0. A strobe while the fault is still qualified has no effect.
- R8: fault_irq follows the latched trip one clock later, gated by the interrupt-enable bit (control bit 4 for three pairs). With that bit at 0, fault_irq stays 0 during a trip.
- R9: After reset, all output enables are 1, pwm_hi is 0, and fault_irq and fault_level are 0. Deadband registers are at addresses 3+NPAIR+i and reset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW (4) | Register address |
| wr_data | input | CW (16) | Register write data |
| clr_fault | input | 1 | One-clock strobe that clears a latched trip |
| fault_n | input | 1 | Asynchronous active-low fault input |
| pwm_hi | output | NPAIR (3) | High-side output of each pair |
| pwm_lo | output | NPAIR (3) | Low-side output of each pair |
| pwm_oe | output | NPAIR (3) | Output enable per pair; 0 means high impedance |
| fault_irq | output | 1 | Maskable fault interrupt |
| fault_level | output | 1 | Qualified fault status |

## Verification
The bench builds the block with its default parameters: three pairs, 16-bit counter and deadband, and a 4-bit qualification counter. It then programs periods of only 8 to 99 clocks. Short periods make a complete period fit inside a counting window of a few dozen cycles, in both counting modes. The duty and deadband arithmetic can therefore be compared exactly, including compare values of zero and above the period. A qualification length of 4, and then 2, puts the shortest ignored pulse and the shortest accepted pulse within a few clocks of each other, so both sides of that boundary are checked cycle by cycle.

// File: rtl/pwm_tripgen_pkg.sv
package pwm_tripgen_pkg;
  typedef enum logic {DIR_UP = 1'b0, DIR_DOWN = 1'b1} cnt_dir_e;

  localparam int ADDR_PERIOD = 0;
  localparam int ADDR_CTRL   = 1;
  localparam int ADDR_QUAL   = 2;
  localparam int ADDR_CMP0   = 3;
endpackage

// File: rtl/pwm_timebase.sv
module pwm_timebase
  import pwm_tripgen_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sym,
  input  logic [CW-1:0] per_sh,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] per_act,
  output logic          at_zero
);
  cnt_dir_e dir;

  assign at_zero = (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      per_act <= '0;
      dir     <= DIR_UP;
    end else begin
      if (at_zero) per_act <= per_sh;
      if (!sym) begin
        dir <= DIR_UP;
        cnt <= (cnt >= per_act) ? '0 : cnt + 1'b1;
      end else if (dir == DIR_UP) begin
        if (cnt >= per_act) begin
          if (per_act == '0) begin
            cnt <= '0;
          end else begin
            cnt <= cnt - 1'b1;
            dir <= DIR_DOWN;
          end
        end else begin
          cnt <= cnt + 1'b1;
        end
      end else begin
        if (cnt <= 1) begin
          cnt <= '0;
          dir <= DIR_UP;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pwm_deadband.sv
module pwm_deadband #(
  parameter int DBW = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           d,
  input  logic [DBW-1:0] db,
  output logic           hi,
  output logic           lo
);
  logic           prev;
  logic [DBW-1:0] run, run_n;

  always_comb begin
    if (d != prev)      run_n = '0;
    else if (run != '1) run_n = run + 1'b1;
    else                run_n = run;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev <= 1'b0;
      run  <= '0;
      hi   <= 1'b0;
      lo   <= 1'b0;
    end else begin
      prev <= d;
      run  <= run_n;
      hi   <= d  && (run_n >= db);
      lo   <= !d && (run_n >= db);
    end
  end
endmodule

// File: rtl/pwm_faultqual.sv
module pwm_faultqual #(
  parameter int QW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fault_n,
  input  logic [QW-1:0] qlen,
  output logic          level
);
  logic          s1, s2;
  logic [QW-1:0] qcnt, qcnt_n;

  always_comb begin
    if (s2)              qcnt_n = '0;
    else if (qcnt != '1) qcnt_n = qcnt + 1'b1;
    else                 qcnt_n = qcnt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1    <= 1'b1;
      s2    <= 1'b1;
      qcnt  <= '0;
      level <= 1'b0;
    end else begin
      s1    <= fault_n;
      s2    <= s1;
      qcnt  <= qcnt_n;
      level <= !s2 && (qcnt_n >= qlen);
    end
  end
endmodule

// File: rtl/pwm_tripgen.sv
module pwm_tripgen
  import pwm_tripgen_pkg::*;
#(
  parameter int NPAIR = 3,
  parameter int CW    = 16,
  parameter int QW    = 4,
  parameter int AW    = 4,
  parameter int QRST  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [CW-1:0]    wr_data,
  input  logic             clr_fault,
  input  logic             fault_n,
  output logic [NPAIR-1:0] pwm_hi,
  output logic [NPAIR-1:0] pwm_lo,
  output logic [NPAIR-1:0] pwm_oe,
  output logic             fault_irq,
  output logic             fault_level
);
  localparam int DB_BASE = ADDR_CMP0 + NPAIR;
  localparam int IRQ_BIT = NPAIR + 1;

  logic [CW-1:0]    per_sh, per_act, cnt;
  logic [CW-1:0]    cmp_sh  [NPAIR];
  logic [CW-1:0]    cmp_act [NPAIR];
  logic [CW-1:0]    db_reg  [NPAIR];
  logic [NPAIR-1:0] raw_q, trip_en;
  logic [QW-1:0]    qlen;
  logic             sym, irq_en, at_zero, tripped;

  // register write port
  always_ff @(posedge clk) begin
    if (rst) begin
      per_sh  <= '0;
      sym     <= 1'b0;
      trip_en <= '1;
      irq_en  <= 1'b0;
      qlen    <= QW'(QRST);
      for (int i = 0; i < NPAIR; i++) begin
        cmp_sh[i] <= '0;
        db_reg[i] <= '0;
      end
    end else if (wr_en) begin
      if (wr_addr == AW'(ADDR_PERIOD)) per_sh <= wr_data;
      if (wr_addr == AW'(ADDR_CTRL)) begin
        sym     <= wr_data[0];
        trip_en <= wr_data[NPAIR:1];
        irq_en  <= wr_data[IRQ_BIT];
      end
      if (wr_addr == AW'(ADDR_QUAL)) qlen <= wr_data[QW-1:0];
      for (int i = 0; i < NPAIR; i++) begin
        if (wr_addr == AW'(ADDR_CMP0 + i)) cmp_sh[i] <= wr_data;
        if (wr_addr == AW'(DB_BASE + i))   db_reg[i] <= wr_data;
      end
    end
  end

  pwm_timebase #(.CW(CW)) u_tb (
    .clk(clk), .rst(rst), .sym(sym), .per_sh(per_sh),
    .cnt(cnt), .per_act(per_act), .at_zero(at_zero)
  );

  generate
    for (genvar g = 0; g < NPAIR; g++) begin : g_pair
      always_ff @(posedge clk) begin
        if (rst) begin
          cmp_act[g] <= '0;
          raw_q[g]   <= 1'b0;
        end else begin
          if (at_zero) cmp_act[g] <= cmp_sh[g];
          raw_q[g] <= (cnt < cmp_act[g]);
        end
      end

      pwm_deadband #(.DBW(CW)) u_db (
        .clk(clk), .rst(rst), .d(raw_q[g]), .db(db_reg[g]),
        .hi(pwm_hi[g]), .lo(pwm_lo[g])
      );
    end
  endgenerate

  pwm_faultqual #(.QW(QW)) u_fq (
    .clk(clk), .rst(rst), .fault_n(fault_n), .qlen(qlen), .level(fault_level)
  );

  // trip latch, output enables and interrupt
  always_ff @(posedge clk) begin
    if (rst) begin
      tripped   <= 1'b0;
      pwm_oe    <= '1;
      fault_irq <= 1'b0;
    end else begin
      if (fault_level)    tripped <= 1'b1;
      else if (clr_fault) tripped <= 1'b0;
      pwm_oe    <= ~(tripped ? trip_en : '0);
      fault_irq <= tripped & irq_en;
    end
  end
endmodule

// File: rtl/pwm_tripgen_chk.sv
module pwm_tripgen_chk #(
  parameter int NPAIR = 3,
  parameter int CW    = 16
) (
  input logic             clk,
  input logic             rst,
  input logic [NPAIR-1:0] pwm_hi,
  input logic [NPAIR-1:0] pwm_lo,
  input logic [NPAIR-1:0] pwm_oe,
  input logic             fault_irq,
  input logic             fault_level,
  input logic             clr_fault,
  input logic             tripped,
  input logic [NPAIR-1:0] trip_en,
  input logic [CW-1:0]    cnt,
  input logic [CW-1:0]    per_act
);
  a_r3_no_overlap: assert property (@(posedge clk) disable iff (rst)
    (pwm_hi & pwm_lo) == '0);

  a_r4_period_held: assert property (@(posedge clk) disable iff (rst)
    (cnt != '0) |=> $stable(per_act));

  a_r5_level_trips: assert property (@(posedge clk) disable iff (rst)
    fault_level |=> tripped);

  a_r6_oe_dropped: assert property (@(posedge clk) disable iff (rst)
    tripped |=> ((pwm_oe & $past(trip_en)) == '0));

  a_r6_oe_restored: assert property (@(posedge clk) disable iff (rst)
    !tripped |=> (pwm_oe == '1));

  a_r7_trip_held: assert property (@(posedge clk) disable iff (rst)
    (tripped && !clr_fault) |=> tripped);

  a_r8_irq_source: assert property (@(posedge clk) disable iff (rst)
    fault_irq |-> $past(tripped));
endmodule

bind pwm_tripgen pwm_tripgen_chk #(.NPAIR(NPAIR), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .pwm_hi(pwm_hi), .pwm_lo(pwm_lo), .pwm_oe(pwm_oe),
  .fault_irq(fault_irq), .fault_level(fault_level), .clr_fault(clr_fault),
  .tripped(tripped), .trip_en(trip_en), .cnt(cnt), .per_act(per_act)
);

// File: tb/tb_pwm_tripgen.sv
module tb_pwm_tripgen;
  localparam int NP = 3;
  localparam int NV = 7;
  // stimulus / expected vectors: mode, period, compare, deadband, hi clocks, lo clocks
  localparam int V_SYM [NV] = '{0, 0, 0, 1, 1, 0, 0};
  localparam int V_PER [NV] = '{9, 9, 19, 8, 10, 9, 9};
  localparam int V_CMP [NV] = '{4, 4, 10, 3, 5, 0, 12};
  localparam int V_DB  [NV] = '{1, 0, 3, 1, 2, 2, 2};
  localparam int V_HI  [NV] = '{3, 4, 7, 4, 7, 0, 10};
  localparam int V_LO  [NV] = '{5, 6, 7, 10, 9, 10, 0};

  logic          clk = 0, rst = 1, wr_en = 0, clr_fault = 0, fault_n = 1;
  logic [3:0]    wr_addr = 0;
  logic [15:0]   wr_data = 0;
  logic [NP-1:0] pwm_hi, pwm_lo, pwm_oe;
  logic          fault_irq, fault_level;
  int checks = 0, errors = 0;

  pwm_tripgen dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .clr_fault(clr_fault), .fault_n(fault_n), .pwm_hi(pwm_hi), .pwm_lo(pwm_lo),
    .pwm_oe(pwm_oe), .fault_irq(fault_irq), .fault_level(fault_level)
  );

  always #4 clk = ~clk;

  task automatic chk(input string rq, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1; wr_addr = 4'(a); wr_data = 16'(d);
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic pulse_clr();
    @(negedge clk); clr_fault = 1;
    @(negedge clk); clr_fault = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle(3);
    rst = 0;
    idle(2);
    // R9 reset state
    chk("R9", "pwm_hi", int'(pwm_hi), 0);
    chk("R9", "pwm_oe", int'(pwm_oe), 7);
    chk("R9", "fault_irq", int'(fault_irq), 0);
    chk("R9", "fault_level", int'(fault_level), 0);

    // R1 R2 R3 vector table
    for (int v = 0; v < NV; v++) begin
      int hc [NP];
      int lc [NP];
      int ov, len;
      string rq;
      rq = (V_SYM[v] != 0) ? "R2/R3" : "R1/R3";
      wr(1, V_SYM[v] | (7 << 1));
      wr(0, V_PER[v]);
      for (int i = 0; i < NP; i++) begin
        wr(3 + i, V_CMP[v]);
        wr(6 + i, V_DB[v]);
      end
      idle(120);
      len = (V_SYM[v] != 0) ? 2 * V_PER[v] : V_PER[v] + 1;
      ov = 0;
      for (int i = 0; i < NP; i++) begin hc[i] = 0; lc[i] = 0; end
      for (int c = 0; c < len; c++) begin
        @(negedge clk);
        for (int i = 0; i < NP; i++) begin
          hc[i] += int'(pwm_hi[i]);
          lc[i] += int'(pwm_lo[i]);
        end
        if ((pwm_hi & pwm_lo) != 0) ov++;
      end
      for (int i = 0; i < NP; i++) begin
        chk(rq, $sformatf("vec%0d pair%0d hi clocks", v, i), hc[i], V_HI[v]);
        chk(rq, $sformatf("vec%0d pair%0d lo clocks", v, i), lc[i], V_LO[v]);
      end
      chk("R3", $sformatf("vec%0d overlap clocks", v), ov, 0);
    end

    // R4 compare shadow: mid-period write must not change the running period
    begin
      int hc;
      wr(1, 7 << 1);
      wr(0, 99);
      for (int i = 0; i < NP; i++) begin wr(3 + i, 50); wr(6 + i, 0); end
      idle(250);
      while (pwm_hi[0] != 1'b1) @(negedge clk);
      while (pwm_hi[0] != 1'b0) @(negedge clk);
      wr(3, 80);
      hc = 0;
      for (int c = 0; c < 20; c++) begin @(negedge clk); hc += int'(pwm_hi[0]); end
      chk("R4", "hi clocks after mid-period write", hc, 0);
      idle(150);
      hc = 0;
      for (int c = 0; c < 100; c++) begin @(negedge clk); hc += int'(pwm_hi[0]); end
      chk("R4", "hi clocks after reload", hc, 80);
    end

    // R5 short pulse rejected; pairs 0 and 2 trip-enabled, irq enabled
    wr(1, (5 << 1) | (1 << 4));
    @(negedge clk); fault_n = 0;
    idle(3);
    fault_n = 1;
    idle(10);
    chk("R5", "fault_level after 3-clock pulse", int'(fault_level), 0);
    chk("R5", "pwm_oe after 3-clock pulse", int'(pwm_oe), 7);

    // R5 R6 R8 exact trip timing
    @(negedge clk); fault_n = 0;
    idle(5);
    chk("R5", "fault_level after edge 5", int'(fault_level), 0);
    idle(1);
    chk("R5", "fault_level after edge 6", int'(fault_level), 1);
    idle(1);
    chk("R6", "pwm_oe after edge 7", int'(pwm_oe), 7);
    idle(1);
    chk("R6", "pwm_oe masked trip", int'(pwm_oe), 2);
    chk("R8", "fault_irq enabled", int'(fault_irq), 1);

    // R7 clear ignored while fault qualified
    pulse_clr();
    idle(3);
    chk("R7", "pwm_oe after clear during fault", int'(pwm_oe), 2);
    fault_n = 1;
    idle(10);
    chk("R5", "fault_level after release", int'(fault_level), 0);
    chk("R7", "trip latched after release", int'(pwm_oe), 2);
    pulse_clr();
    idle(3);
    chk("R7", "pwm_oe after clear", int'(pwm_oe), 7);
    chk("R8", "fault_irq after clear", int'(fault_irq), 0);

    // R8 interrupt masked, all pairs trip-enabled
    wr(1, 7 << 1);
    @(negedge clk); fault_n = 0;
    idle(12);
    chk("R6", "pwm_oe all pairs tripped", int'(pwm_oe), 0);
    chk("R8", "fault_irq masked", int'(fault_irq), 0);
    fault_n = 1;
    idle(6);
    pulse_clr();
    idle(3);
    chk("R7", "pwm_oe restored", int'(pwm_oe), 7);

    // R5 programmable qualification length of 2
    wr(2, 2);
    @(negedge clk); fault_n = 0;
    idle(2);
    fault_n = 1;
    idle(8);
    chk("R5", "pwm_oe after 2-clock pulse with Q=2", int'(pwm_oe), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule